// File: doc/BRIEF.md
# Burst Pattern Write Master

This block moves a stream of generated test words into memory. A sequencer hands it one block command at a time on a valid/ready command port. The command holds a byte start address and a byte length. The block then takes words from a separate valid/ready data stream and writes them through a memory-mapped master that supports bursts. It splits each block into bursts of at most `MAX_BURST` words, which is 2 by default. When `REALIGN` is set, no burst crosses a `MAX_BURST`-word address boundary. A block that starts off a boundary therefore begins with a short burst that stops at the next boundary. The block accepts the next command only after every word of the current block has been written.

The controller runs a three-state machine. In `ST_IDLE` it offers `cmd_ready`. The transition "accept" goes to `ST_PLAN` when a command with a nonzero word count arrives. A zero-length command is consumed and the machine stays in `ST_IDLE`. In `ST_PLAN` the controller sizes the next burst and latches its start address and length. The transition "launch" always leads to `ST_BURST`. In `ST_BURST` each beat is written when the stream has data and the slave is not stalling. After the last beat of a burst, the transition "next" goes back to `ST_PLAN` if words remain in the block. Otherwise the transition "done" goes to `ST_IDLE`.

Top module: `burst_pattern_writer`

## Requirements
- R1: After reset, and at any time a reset is applied, `cmd_ready` is 1 and both `mem_write` and `din_ready` are 0.
- R2: `cmd_ready` is 1 only while no block is in flight. It is 0 from the cycle after a nonzero command is accepted until the last word of that block has been written.
- R3: Every burst has a `mem_burstcount` between 1 and `MAX_BURST` inclusive.
- R4: With `REALIGN` set, a burst starting at word address A (byte address divided by the word size in bytes) carries at most `MAX_BURST - (A mod MAX_BURST)` beats, so it never crosses a boundary.
- R5: Each burst takes the largest allowed length. That length is the smaller of the words left in the block and the limit of R3/R4. As a result, only the first burst and the last burst of a block can be short.
- R6: While `mem_write` is 1 and `mem_waitrequest` is 1, `mem_address` and `mem_burstcount` keep their values in the next cycle.
- R7: `din_ready` is 1 only when a beat can be written: a burst is in progress and `mem_waitrequest` is 0. Every stream word is written exactly once, in order, to consecutive word addresses.
- R8: During a burst, `mem_write` follows `din_valid`. A beat is written exactly when `din_valid` and `din_ready` are both 1.
- R9: A command of length 0 causes no memory write and leaves `cmd_ready` at 1. A block of N words (byte length divided by the word size) causes exactly N beats and then returns `cmd_ready` to 1.
- R10: The `mem_address` of each burst equals the command byte address plus the word size times the number of words already written in that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Block command offered |
| cmd_ready | output | 1 | Idle; ready for a new block command |
| cmd_addr | input | ADDR_W | Block start byte address, word aligned |
| cmd_len | input | LEN_W | Block length in bytes, a multiple of the word size |
| din_valid | input | 1 | Stream word offered |
| din_ready | output | 1 | Stream word will be written this cycle if valid |
| din_data | input | DATA_W | Stream word |
| mem_address | output | ADDR_W | Burst start byte address |
| mem_write | output | 1 | Write beat request |
| mem_writedata | output | DATA_W | Write beat data |
| mem_burstcount | output | BC_W | Beats in the current burst |
| mem_waitrequest | input | 1 | Slave stall |

## Verification
The bench sends blocks that start on a boundary, blocks that start one word past a boundary, and blocks of one or two words. These cases catch a sizer that ignores the start offset and writes a burst across the boundary, or one that writes a full burst past the end of the block. Random stalls of both the slave and the stream test that the burst address stays stable under `mem_waitrequest` and that no word is dropped or written twice. A `din_ready` that did not depend on the stall would consume words that never reach memory. A zero-length command and a reset in the middle of a burst test that the machine returns to idle cleanly and does not hang or keep writing.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAN  = 2'd1,
        ST_BURST = 2'd2
    } bpw_state_e;
endpackage

// File: rtl/bpw_burst_sizer.sv
module bpw_burst_sizer #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 2,
    parameter bit REALIGN   = 1'b1,
    localparam int BC_W     = $clog2(MAX_BURST) + 1
) (
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [LEN_W-1:0]  words_left,
    output logic [BC_W-1:0]   burst_len
);
    logic [LEN_W-1:0] span;
    logic [LEN_W-1:0] pick;

    generate
        if (REALIGN) begin : g_align
            // words until the next MAX_BURST-word boundary
            assign span = LEN_W'(MAX_BURST)
                        - LEN_W'(word_addr % ADDR_W'(MAX_BURST));
        end else begin : g_plain
            assign span = LEN_W'(MAX_BURST);
        end
    endgenerate

    assign pick      = (words_left < span) ? words_left : span;
    assign burst_len = BC_W'(pick);
endmodule

// File: rtl/bpw_beat_tracker.sv
module bpw_beat_tracker #(
    parameter int MAX_BURST = 2,
    localparam int BC_W     = $clog2(MAX_BURST) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BC_W-1:0] load_len,
    input  logic            beat,
    output logic            last
);
    logic [BC_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_len;
        end else if (beat) begin
            left_q <= left_q - BC_W'(1);
        end
    end

    assign last = (left_q == BC_W'(1));
endmodule

// File: rtl/burst_pattern_writer.sv
module burst_pattern_writer
    import bpw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 2,
    parameter bit REALIGN   = 1'b1,
    localparam int BC_W     = $clog2(MAX_BURST) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [DATA_W-1:0] din_data,
    output logic [ADDR_W-1:0] mem_address,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_writedata,
    output logic [BC_W-1:0]   mem_burstcount,
    input  logic              mem_waitrequest
);
    localparam int BYTES     = DATA_W / 8;
    localparam int LOG_BYTES = $clog2(BYTES);

    bpw_state_e        state_q, state_d;
    logic [ADDR_W-1:0] word_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  left_q;
    logic [BC_W-1:0]   blen_q;
    logic [BC_W-1:0]   plan_len;
    logic [LEN_W-1:0]  cmd_words;
    logic              beat;
    logic              last_beat;
    logic              take_cmd;

    assign cmd_words = LEN_W'(cmd_len >> LOG_BYTES);
    assign take_cmd  = (state_q == ST_IDLE) && cmd_valid;
    assign beat      = (state_q == ST_BURST) && din_valid && !mem_waitrequest;

    bpw_burst_sizer #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .MAX_BURST(MAX_BURST),
        .REALIGN  (REALIGN)
    ) u_sizer (
        .word_addr (word_q),
        .words_left(left_q),
        .burst_len (plan_len)
    );

    bpw_beat_tracker #(
        .MAX_BURST(MAX_BURST)
    ) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_PLAN),
        .load_len(plan_len),
        .beat    (beat),
        .last    (last_beat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        din_ready = 1'b0;
        mem_write = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid && (cmd_words != '0)) begin
                    state_d = ST_PLAN;           // accept
                end
            end
            ST_PLAN: begin
                state_d = ST_BURST;              // launch
            end
            ST_BURST: begin
                din_ready = !mem_waitrequest;
                mem_write = din_valid;
                if (beat && last_beat) begin
                    state_d = (left_q == LEN_W'(1)) ? ST_IDLE   // done
                                                    : ST_PLAN;  // next
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // block and burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
            base_q <= '0;
            blen_q <= '0;
        end else begin
            if (take_cmd) begin
                word_q <= cmd_addr >> LOG_BYTES;
                left_q <= cmd_words;
            end else if (beat) begin
                word_q <= word_q + ADDR_W'(1);
                left_q <= left_q - LEN_W'(1);
            end
            if (state_q == ST_PLAN) begin
                base_q <= word_q;
                blen_q <= plan_len;
            end
        end
    end

    assign mem_address    = ADDR_W'(base_q << LOG_BYTES);
    assign mem_burstcount = blen_q;
    assign mem_writedata  = din_data;
endmodule

// File: rtl/burst_pattern_writer_chk.sv
module burst_pattern_writer_chk #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 2,
    parameter bit REALIGN   = 1'b1,
    localparam int BC_W     = $clog2(MAX_BURST) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              din_valid,
    input logic              din_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_address,
    input logic [BC_W-1:0]   mem_burstcount,
    input logic              mem_waitrequest
);
    localparam int LOG_BYTES = $clog2(DATA_W / 8);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_write && !din_ready));

    p_burst_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> (mem_burstcount >= BC_W'(1)) && (int'(mem_burstcount) <= MAX_BURST));

    p_no_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> (!REALIGN ||
            (int'((mem_address >> LOG_BYTES) % ADDR_W'(MAX_BURST))
             + int'(mem_burstcount) <= MAX_BURST)));

    p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write && mem_waitrequest) |=> ($stable(mem_address) && $stable(mem_burstcount)));

    p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> (!mem_waitrequest && !cmd_ready));

    p_write_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> (mem_write == din_valid));
endmodule

bind burst_pattern_writer burst_pattern_writer_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MAX_BURST(MAX_BURST),
    .REALIGN  (REALIGN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_ready      (cmd_ready),
    .din_valid      (din_valid),
    .din_ready      (din_ready),
    .mem_write      (mem_write),
    .mem_address    (mem_address),
    .mem_burstcount (mem_burstcount),
    .mem_waitrequest(mem_waitrequest)
);

// File: tb/burst_pattern_writer_bench.sv
module burst_pattern_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 16;
    localparam int MAX_BURST  = 2;
    localparam int BC_W       = $clog2(MAX_BURST) + 1;
    localparam int NVEC       = 6;
    // byte address, byte length, stall enable
    localparam int VADDR [NVEC] = '{0, 4, 12, 20, 32, 100};
    localparam int VLEN  [NVEC] = '{16, 16, 4, 8, 20, 24};
    localparam int VSTAL [NVEC] = '{0, 1, 0, 1, 1, 1};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              din_valid;
    logic              din_ready;
    logic [DATA_W-1:0] din_data;
    logic [ADDR_W-1:0] mem_address;
    logic              mem_write;
    logic [DATA_W-1:0] mem_writedata;
    logic [BC_W-1:0]   mem_burstcount;
    logic              mem_waitrequest;

    logic              stall = 1'b0;
    logic [7:0]        lfsr = 8'h5B;
    int                src_cnt = 0;
    logic [31:0]       mem [0:127];
    logic [31:0]       blog_a [0:63];
    int                blog_c [0:63];
    int                nb = 0;
    int                bidx = 0;
    int                hold_viol = 0;
    int                beat_viol = 0;
    logic              hold_pend = 1'b0;
    logic [ADDR_W-1:0] h_addr;
    logic [BC_W-1:0]   h_cnt;
    int                n_tests = 0;
    int                n_fail = 0;
    int                cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_pattern_writer u_burst_pattern_writer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_ready      (cmd_ready),
        .cmd_addr       (cmd_addr),
        .cmd_len        (cmd_len),
        .din_valid      (din_valid),
        .din_ready      (din_ready),
        .din_data       (din_data),
        .mem_address    (mem_address),
        .mem_write      (mem_write),
        .mem_writedata  (mem_writedata),
        .mem_burstcount (mem_burstcount),
        .mem_waitrequest(mem_waitrequest)
    );

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h01010101) ^ 32'h5A00C300;
    endfunction

    // stall generator and pattern source
    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign mem_waitrequest = stall & lfsr[0];
    assign din_valid       = !stall | lfsr[2];
    assign din_data        = pat(src_cnt);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && din_valid && din_ready) src_cnt <= src_cnt + 1;
    end

    // memory model with burst tracking, plus protocol monitors
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bidx      <= 0;
            hold_pend <= 1'b0;
        end else begin
            if (mem_write && !mem_waitrequest) begin
                if (bidx == 0) begin
                    blog_a[nb[5:0]] <= mem_address;
                    blog_c[nb[5:0]] <= int'(mem_burstcount);
                    nb <= nb + 1;
                end
                mem[7'((mem_address >> 2) + 32'(bidx))] <= mem_writedata;
                bidx <= (bidx + 1 >= int'(mem_burstcount)) ? 0 : bidx + 1;
            end
            if (hold_pend && (mem_address != h_addr || mem_burstcount != h_cnt))
                hold_viol <= hold_viol + 1;
            hold_pend <= mem_write && mem_waitrequest;
            h_addr    <= mem_address;
            h_cnt     <= mem_burstcount;
            if ((din_valid && din_ready) != (mem_write && !mem_waitrequest))
                beat_viol <= beat_viol + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (cmd_ready) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_block(input int addr, input int len, input bit stl);
        int src0, nb0, a, r, k, w, n;
        bit ok;
        wait_idle(ok);
        stall     = stl;
        src0      = src_cnt;
        nb0       = nb;
        cmd_addr  = ADDR_W'(addr);
        cmd_len   = LEN_W'(len);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (len > 0)
            check(!cmd_ready, "R2 busy after accept", 32'(cmd_ready), 32'd0);
        wait_idle(ok);
        check(ok, "R9 block completes", 32'(ok), 32'd1);
        stall = 1'b0;
        n = len / 4;
        // expected burst sequence from the sizing rules
        a = addr / 4;
        r = n;
        k = 0;
        w = 0;
        while (r > 0) begin
            int lim, exp_c;
            lim   = MAX_BURST - (a % MAX_BURST);
            exp_c = (r < lim) ? r : lim;
            if (nb0 + k < nb) begin
                check(blog_c[(nb0 + k) % 64] == exp_c,
                      (k == 0) ? "R4 first burst length" : "R5 burst length",
                      32'(blog_c[(nb0 + k) % 64]), 32'(exp_c));
                check(blog_a[(nb0 + k) % 64] == 32'(addr + 4 * w), "R10 burst address",
                      blog_a[(nb0 + k) % 64], 32'(addr + 4 * w));
            end
            a += exp_c;
            r -= exp_c;
            w += exp_c;
            k++;
        end
        check(nb - nb0 == k, "R3 burst count", 32'(nb - nb0), 32'(k));
        check(src_cnt - src0 == n, "R9 beats per block", 32'(src_cnt - src0), 32'(n));
        for (int i = 0; i < n; i++)
            check(mem[(addr / 4 + i) % 128] == pat(src0 + i), "R7 word order",
                  mem[(addr / 4 + i) % 128], pat(src0 + i));
    endtask

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        check(cmd_ready && !mem_write && !din_ready, "R1 reset state",
              {29'd0, cmd_ready, mem_write, din_ready}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++)
            run_block(VADDR[v], VLEN[v], VSTAL[v] != 0);

        // zero-length command: no write, stays idle (R9)
        begin
            int nb0;
            nb0       = nb;
            cmd_addr  = 32'd40;
            cmd_len   = '0;
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            check(cmd_ready, "R9 zero length idle", 32'(cmd_ready), 32'd1);
            repeat (3) @(negedge clk);
            check(nb == nb0 && !mem_write, "R9 zero length no write", 32'(nb - nb0), 32'd0);
        end

        // reset in the middle of a block (R1)
        cmd_addr  = 32'd64;
        cmd_len   = 16'd24;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(cmd_ready && !mem_write && !din_ready, "R1 mid-block reset",
              {29'd0, cmd_ready, mem_write, din_ready}, 32'h4);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !mem_write, "R1 idle after reset", 32'(cmd_ready), 32'd1);

        // block after the reset still works, unaligned with stalls
        run_block(60, 28, 1'b1);

        check(hold_viol == 0, "R6 hold under stall", 32'(hold_viol), 32'd0);
        check(beat_viol == 0, "R8 beat handshake", 32'(beat_viol), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule